// File: doc/BRIEF.md
# Windowed Multithreaded Register File

This block holds the integer working registers of several hardware threads. Each thread's registers are arranged as a ring of overlapping windows. The caller's out registers are the same physical storage as the callee's in registers, so a procedure call and its return only move a pointer and copy no arguments. Each access names a thread and a 5-bit register specifier. The block turns the specifier into a physical entry through that thread's current window pointer.

Three read ports return data combinationally from the stored state. Two write ports commit at the clock edge. One write port carries short-latency results and the other carries long-latency results. A window command (save or restore for one thread) moves that thread's pointer around the ring. When a save would leave no spare window, or a restore has no caller frame to return to, the command is dropped and a one-cycle flag is raised in place of a trap.

Top module: `rwin_regfile`

## Requirements
- R1: After synchronous active-high reset, every register of every thread reads zero, both flags are low, every window pointer sits at window 6 and every thread has zero nested saves.
- R2: Specifier codes 0-7 select out registers, 8-15 select local registers and 16-23 select in registers, with the register number in bits 2:0. Codes 24-31 read as zero, and a write with such a code changes no register.
- R3: Out register k of window w and in register k of window w+1 (modulo 8) are one physical register.
- R4: Local registers belong to a single window: after a save, the local registers of the new window are distinct from those of the caller.
- R5: The ring is circular, so out register k of window 7 is in register k of window 0.
- R6: A save increments the thread's window pointer modulo 8 and a restore decrements it. A save made with 6 saves already outstanding is dropped, and it drives the overflow flag high in the next cycle.
- R7: A restore made with no outstanding save is dropped, and it drives the underflow flag high for exactly one cycle.
- R8: Threads are isolated. A window command or a write for one thread does not change what another thread reads.
- R9: The three read ports work independently, each with its own thread and specifier, in the same cycle.
- R10: The two write ports commit in the same cycle. When both target the same physical register, the long-latency port's data is kept.
- R11: A read in the same cycle as a write to the same register returns the value held before that write.
- R12: A window command changes the mapping only from the next cycle. Reads and writes in the command's own cycle use the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | 1 | Window command valid |
| win_save | input | 1 | 1 = save, 0 = restore |
| win_tid | input | 2 | Thread addressed by the window command |
| rd_tid | input | 3x2 | Thread for each read port |
| rd_spec | input | 3x5 | Register specifier for each read port |
| rd_data | output | 3x64 | Read data for each port |
| ws_en | input | 1 | Short-latency write enable |
| ws_tid | input | 2 | Short-latency write thread |
| ws_spec | input | 5 | Short-latency write specifier |
| ws_data | input | 64 | Short-latency write data |
| wl_en | input | 1 | Long-latency write enable |
| wl_tid | input | 2 | Long-latency write thread |
| wl_spec | input | 5 | Long-latency write specifier |
| wl_data | input | 64 | Long-latency write data |
| ovf_o | output | 1 | One-cycle pulse: a save was dropped |
| unf_o | output | 1 | One-cycle pulse: a restore was dropped |

## Verification
The hardest condition to reach is overflow. It needs six accepted saves on a single thread before a seventh save can be refused. The stimulus issues a run of back-to-back saves on a thread whose pointer the other checks never touched. It writes a local register in the deepest window, then issues the seventh save. After that save the bench checks both the flag and that the same local register still reads back, which shows the pointer did not move. The ring wrap is reached in the same way: the reset pointer is window 6, so two saves take a thread across the window 7 to window 0 boundary.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    parameter int NTHR    = 4;
    parameter int NWIN    = 8;
    parameter int NREG    = 8;
    parameter int DW      = 64;
    parameter int NRD     = 3;
    parameter int CWP_RST = NWIN - 2;

    localparam int TW      = $clog2(NTHR);
    localparam int CW      = $clog2(NWIN);
    localparam int RW      = $clog2(NREG);
    localparam int SW      = RW + 2;
    localparam int PIW     = TW + CW + 1 + RW;
    localparam int ENTRIES = NTHR * NWIN * 2 * NREG;
    localparam int MAXDEP  = NWIN - 2;
    localparam int DPW     = $clog2(NWIN);

    typedef enum logic [1:0] {
        CLS_OUT   = 2'd0,
        CLS_LOCAL = 2'd1,
        CLS_IN    = 2'd2,
        CLS_BAD   = 2'd3
    } spec_cls_e;

    typedef struct packed {
        logic           vld;
        logic [PIW-1:0] idx;
    } phys_ref_t;

    function automatic spec_cls_e spec_class(input logic [SW-1:0] s);
        return spec_cls_e'(s[SW-1:SW-2]);
    endfunction

    function automatic logic [CW-1:0] win_next(input logic [CW-1:0] w);
        return (w == CW'(NWIN - 1)) ? '0 : w + CW'(1);
    endfunction

    function automatic logic [CW-1:0] win_prev(input logic [CW-1:0] w);
        return (w == '0) ? CW'(NWIN - 1) : w - CW'(1);
    endfunction

endpackage

// File: rtl/rwin_addr_map.sv
module rwin_addr_map
    import rwin_pkg::*;
(
    input  logic [TW-1:0] tid,
    input  logic [SW-1:0] spec,
    input  logic [CW-1:0] cwp,
    output phys_ref_t     ref_o
);

    spec_cls_e       cls;
    logic [CW-1:0]   win;
    logic            half;
    logic [RW-1:0]   reg_no;

    always_comb begin
        cls    = spec_class(spec);
        reg_no = spec[RW-1:0];
        win    = cwp;
        half   = 1'b0;
        unique case (cls)
            CLS_OUT: begin
                win  = win_next(cwp);
                half = 1'b0;
            end
            CLS_LOCAL: begin
                win  = cwp;
                half = 1'b1;
            end
            CLS_IN: begin
                win  = cwp;
                half = 1'b0;
            end
            default: begin
                win  = cwp;
                half = 1'b0;
            end
        endcase
        ref_o.vld = (cls != CLS_BAD);
        ref_o.idx = {tid, win, half, reg_no};
    end

endmodule

// File: rtl/rwin_window_ctrl.sv
module rwin_window_ctrl
    import rwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          save,
    output logic [CW-1:0] cwp,
    output logic          ovf_p,
    output logic          unf_p
);

    logic [DPW-1:0] depth_q;
    logic           at_top;
    logic           at_bot;

    assign at_top = (depth_q == DPW'(MAXDEP));
    assign at_bot = (depth_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp     <= CW'(CWP_RST);
            depth_q <= '0;
            ovf_p   <= 1'b0;
            unf_p   <= 1'b0;
        end else begin
            ovf_p <= 1'b0;
            unf_p <= 1'b0;
            if (hit) begin
                if (save) begin
                    if (at_top) begin
                        ovf_p <= 1'b1;
                    end else begin
                        cwp     <= win_next(cwp);
                        depth_q <= depth_q + DPW'(1);
                    end
                end else begin
                    if (at_bot) begin
                        unf_p <= 1'b1;
                    end else begin
                        cwp     <= win_prev(cwp);
                        depth_q <= depth_q - DPW'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rwin_storage.sv
module rwin_storage
    import rwin_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  phys_ref_t [NRD-1:0]      rd_ref,
    output logic [NRD-1:0][DW-1:0]   rd_data,
    input  logic                     ws_en,
    input  phys_ref_t                ws_ref,
    input  logic [DW-1:0]            ws_data,
    input  logic                     wl_en,
    input  phys_ref_t                wl_ref,
    input  logic [DW-1:0]            wl_data
);

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else begin
            if (ws_en && ws_ref.vld) mem[ws_ref.idx] <= ws_data;
            // long-latency port is written last so it wins a collision
            if (wl_en && wl_ref.vld) mem[wl_ref.idx] <= wl_data;
        end
    end

    always_comb begin
        for (int p = 0; p < NRD; p++) begin
            rd_data[p] = rd_ref[p].vld ? mem[rd_ref[p].idx] : '0;
        end
    end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   win_vld,
    input  logic                   win_save,
    input  logic [TW-1:0]          win_tid,
    input  logic [NRD-1:0][TW-1:0] rd_tid,
    input  logic [NRD-1:0][SW-1:0] rd_spec,
    output logic [NRD-1:0][DW-1:0] rd_data,
    input  logic                   ws_en,
    input  logic [TW-1:0]          ws_tid,
    input  logic [SW-1:0]          ws_spec,
    input  logic [DW-1:0]          ws_data,
    input  logic                   wl_en,
    input  logic [TW-1:0]          wl_tid,
    input  logic [SW-1:0]          wl_spec,
    input  logic [DW-1:0]          wl_data,
    output logic                   ovf_o,
    output logic                   unf_o
);

    logic [NTHR-1:0][CW-1:0] cwp_vec;
    logic [NTHR-1:0]         ovf_vec;
    logic [NTHR-1:0]         unf_vec;
    phys_ref_t [NRD-1:0]     rd_ref;
    phys_ref_t               ws_ref;
    phys_ref_t               wl_ref;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        rwin_window_ctrl u_ctrl (
            .clk   (clk),
            .rst   (rst),
            .hit   (win_vld && (win_tid == TW'(t))),
            .save  (win_save),
            .cwp   (cwp_vec[t]),
            .ovf_p (ovf_vec[t]),
            .unf_p (unf_vec[t])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rwin_addr_map u_map (
            .tid   (rd_tid[p]),
            .spec  (rd_spec[p]),
            .cwp   (cwp_vec[rd_tid[p]]),
            .ref_o (rd_ref[p])
        );
    end

    rwin_addr_map u_map_ws (
        .tid   (ws_tid),
        .spec  (ws_spec),
        .cwp   (cwp_vec[ws_tid]),
        .ref_o (ws_ref)
    );

    rwin_addr_map u_map_wl (
        .tid   (wl_tid),
        .spec  (wl_spec),
        .cwp   (cwp_vec[wl_tid]),
        .ref_o (wl_ref)
    );

    rwin_storage u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_ref  (rd_ref),
        .rd_data (rd_data),
        .ws_en   (ws_en),
        .ws_ref  (ws_ref),
        .ws_data (ws_data),
        .wl_en   (wl_en),
        .wl_ref  (wl_ref),
        .wl_data (wl_data)
    );

    assign ovf_o = |ovf_vec;
    assign unf_o = |unf_vec;

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk
    import rwin_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   win_vld,
    input logic                   win_save,
    input logic [NRD-1:0][SW-1:0] rd_spec,
    input logic [NRD-1:0][DW-1:0] rd_data,
    input logic [NTHR-1:0][CW-1:0] cwp_vec,
    input logic                   ovf_o,
    input logic                   unf_o
);

    // R6
    ovf_after_save_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $past(win_vld && win_save));

    // R7
    unf_after_restore_chk: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> $past(win_vld && !win_save));

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));

    // R12
    cwp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !win_vld |=> $stable(cwp_vec));

    // R2
    bad_spec_rd0_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_spec[0][SW-1:SW-2] == 2'b11) |-> (rd_data[0] == '0));

    // R2
    bad_spec_rd1_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_spec[1][SW-1:SW-2] == 2'b11) |-> (rd_data[1] == '0));

endmodule

bind rwin_regfile rwin_regfile_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .win_vld  (win_vld),
    .win_save (win_save),
    .rd_spec  (rd_spec),
    .rd_data  (rd_data),
    .cwp_vec  (cwp_vec),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
);

// File: tb/rwin_regfile_bench.sv
`timescale 1ns/1ps
module rwin_regfile_bench;
    import rwin_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   win_vld = 1'b0;
    logic                   win_save = 1'b0;
    logic [TW-1:0]          win_tid = '0;
    logic [NRD-1:0][TW-1:0] rd_tid = '0;
    logic [NRD-1:0][SW-1:0] rd_spec = '0;
    logic [NRD-1:0][DW-1:0] rd_data;
    logic                   ws_en = 1'b0;
    logic [TW-1:0]          ws_tid = '0;
    logic [SW-1:0]          ws_spec = '0;
    logic [DW-1:0]          ws_data = '0;
    logic                   wl_en = 1'b0;
    logic [TW-1:0]          wl_tid = '0;
    logic [SW-1:0]          wl_spec = '0;
    logic [DW-1:0]          wl_data = '0;
    logic                   ovf_o;
    logic                   unf_o;

    always #5 clk = ~clk;

    rwin_regfile u_rwin_regfile (.*);

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    localparam logic [63:0] VA = 64'hA0A0_0000_0000_0005;
    localparam logic [63:0] VB = 64'hB0B0_0000_0000_000D;
    localparam logic [63:0] VC = 64'hC0C0_0000_0000_0015;
    localparam logic [63:0] VD = 64'hDDDD_DDDD_DDDD_DDDD;
    localparam logic [63:0] VE = 64'hE0E0_0000_0000_0003;
    localparam logic [63:0] VF = 64'hF0F0_1234_5678_0008;
    localparam logic [63:0] VG = 64'h1111_0000_0000_0009;
    localparam logic [63:0] VH = 64'h2222_0000_0000_000A;
    localparam logic [63:0] VI = 64'h3333_0000_0000_000B;
    localparam logic [63:0] VJ = 64'h4444_0000_0000_000B;
    localparam logic [63:0] VK = 64'h5555_0000_0000_0009;
    localparam logic [63:0] VX = 64'h6666_0000_0000_0001;

    // monitor: compares queued expectations once inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = q.pop_front();
                if (it.kind < NRD) act = rd_data[it.kind];
                else if (it.kind == 3) act = {63'd0, ovf_o};
                else act = {63'd0, unf_o};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        ws_en   = 1'b0;
        wl_en   = 1'b0;
        win_vld = 1'b0;
    endtask

    task automatic push(input int kind, input logic [63:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic rd(input int p, input int tid, input int spec,
                      input logic [63:0] exp, input string tag);
        rd_tid[p]  = TW'(tid);
        rd_spec[p] = SW'(spec);
        push(p, exp, tag);
    endtask

    task automatic wr_s(input int tid, input int spec, input logic [63:0] d);
        ws_en = 1'b1; ws_tid = TW'(tid); ws_spec = SW'(spec); ws_data = d;
    endtask

    task automatic wr_l(input int tid, input int spec, input logic [63:0] d);
        wl_en = 1'b1; wl_tid = TW'(tid); wl_spec = SW'(spec); wl_data = d;
    endtask

    task automatic win(input int tid, input bit save);
        win_vld = 1'b1; win_tid = TW'(tid); win_save = save;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state (thread 0 starts in window 6)
        cyc();
        rd(0, 0, 0, 64'd0, "R1"); rd(1, 0, 8, 64'd0, "R1"); rd(2, 0, 16, 64'd0, "R1");
        push(3, 64'd0, "R1"); push(4, 64'd0, "R1");

        // R2: one register of each class, through both write ports
        cyc(); wr_s(0, 5, VA); wr_l(0, 13, VB);
        cyc(); wr_s(0, 21, VC);
        cyc(); wr_s(0, 27, VD);
        rd(0, 0, 5, VA, "R2"); rd(1, 0, 13, VB, "R2"); rd(2, 0, 21, VC, "R2");
        cyc();
        rd(0, 0, 27, 64'd0, "R2"); rd(1, 0, 13, VB, "R2"); rd(2, 0, 21, VC, "R2");

        // R12: a save's own cycle still sees the old window; R3/R4 after it
        cyc(); win(0, 1'b1); rd(0, 0, 21, VC, "R12");
        cyc();
        rd(0, 0, 21, VA, "R3"); rd(1, 0, 13, 64'd0, "R4"); rd(2, 0, 5, 64'd0, "R4");

        // R5: window 7 outs become window 0 ins
        cyc(); wr_s(0, 3, VE);
        cyc(); win(0, 1'b1);
        cyc(); rd(0, 0, 19, VE, "R5");

        // R6: restores walk back to window 7, then window 6
        cyc(); win(0, 1'b0);
        cyc(); rd(0, 0, 3, VE, "R6"); rd(1, 0, 19, 64'd0, "R6"); win(0, 1'b0);
        cyc(); rd(0, 0, 5, VA, "R6"); rd(1, 0, 13, VB, "R6");

        // R7: restore with nothing outstanding
        cyc(); win(0, 1'b0);
        cyc(); push(4, 64'd1, "R7"); push(3, 64'd0, "R7"); rd(0, 0, 13, VB, "R7");
        cyc(); push(4, 64'd0, "R7");

        // R8: thread 1 activity leaves thread 0 alone
        cyc(); win(1, 1'b1); rd(0, 1, 13, 64'd0, "R8");
        cyc(); wr_s(1, 13, VX);
        cyc(); rd(0, 0, 13, VB, "R8"); rd(1, 1, 13, VX, "R8");

        // R6: overflow on thread 2 after six accepted saves
        for (int i = 0; i < 6; i++) begin
            cyc(); win(2, 1'b1);
        end
        cyc(); wr_s(2, 8, VF); push(3, 64'd0, "R6");
        cyc(); win(2, 1'b1);
        cyc(); push(3, 64'd1, "R6"); rd(0, 2, 8, VF, "R6");
        cyc(); push(3, 64'd0, "R6");

        // R10: dual writes, then a collision
        cyc(); wr_s(3, 9, VG); wr_l(3, 10, VH);
        cyc(); wr_s(3, 11, VI); wr_l(3, 11, VJ);
        rd(0, 3, 9, VG, "R10"); rd(1, 3, 10, VH, "R10");
        cyc(); rd(2, 3, 11, VJ, "R10");

        // R11: read during a write to the same register
        cyc(); wr_s(3, 9, VK); rd(0, 3, 9, VG, "R11");
        cyc(); rd(0, 3, 9, VK, "R11");

        // R9: three ports, three threads at once
        cyc(); rd(0, 0, 13, VB, "R9"); rd(1, 1, 13, VX, "R9"); rd(2, 3, 11, VJ, "R9");

        cyc(); cyc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule